// File: doc/BRIEF.md
# Buffered Multi-Channel PWM Timer

This peripheral provides five independent down-counting timer channels behind a simple 32-bit register port. Each channel owns a period buffer and a compare buffer that software may rewrite at any time. The channel's working counter and working compare value only pick up those buffers at two moments: while software holds the channel's update bit high, or when the counter expires with reload enabled. This double buffering lets software change the waveform without glitching the period that is in progress.

The counter steps down by one on every clock where the shared `tick` input is high. A channel that reaches zero either reloads from its buffers and keeps running, or halts if reload has been cleared. Each expiry latches a per-channel interrupt status bit that software clears by writing one. The PWM output is high from the compare match until the reload, and a per-channel invert bit flips it. Two configuration words are held for software but have no effect on counting.

Top module: `pwm_timer`

## Requirements
- R1: After reset every readable register returns 0 and all `pwm_out` bits are 0.
- R2: Byte addresses: config words at 0x00 and 0x04 (read back as written), control at 0x08, status at 0x44; channel n has its period buffer at 0x0C+12n, compare buffer at 0x10+12n and a read-only live counter at 0x14+12n. Status decode takes priority at 0x44, so the last channel's live counter is not readable. `bus_rdata` shows the addressed register one clock after the address is applied.
- R3: In the control word channel 0's field starts at bit 0 and channel n (n at least 1) at bit 4(n+1); within a field, offset 0 is run, 1 is update, 2 is invert, 3 is reload and 4 is a stored-only dead-zone bit.
- R4: While a channel's update bit is 1, its counter and working compare are loaded from the buffers on every clock and the counter does not step; writing a buffer has no effect on the counter until an update or a reload.
- R5: With run at 1 and update at 0, the counter drops by one on each clock where `tick` is 1 and holds where `tick` is 0.
- R6: When the counter is 0 on a tick and reload is 1, it reloads from both buffers, so one period lasts (period buffer + 1) ticks.
- R7: While running, the non-inverted output is 1 when the counter is at or below the working compare value and 0 otherwise, giving (compare + 1) high ticks per period; a channel that is not running outputs 0 before inversion. The output is registered and lags the counter by one clock.
- R8: The invert bit flips the channel's output, both running and idle.
- R9: When the counter is 0 on a tick and reload is 0, the channel halts with the counter at 0 and its output at the idle level until the next update.
- R10: Each expiry sets status bit n at 0x44; writing 1 to a bit clears it, writing 0 leaves it, and a new expiry in the same clock wins over the clear.
- R11: A period buffer written while the channel runs does not alter the period in progress; the new value is used from the next reload.
- R12: The live counter register reads the channel's current count, dropping by one per tick while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable shared by all channels |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | NCH (5) | Per-channel PWM outputs |

## Verification
A wrong counter or a working compare value taken from the buffer at the wrong moment shows at the ports as a rise-to-rise interval or high time that differs from the programmed buffers within the next full period, and as a live-counter read that jumps instead of stepping down. A halt flag that fails to set or clear shows as an output that keeps toggling, or stays frozen, within one period after reload is cleared or an update is issued. A status bit that sets late, clears on a zero write or fails to clear appears in the next read of 0x44.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int DW = 32;

  // fixed register offsets
  localparam int A_CFG0 = 'h00;
  localparam int A_CFG1 = 'h04;
  localparam int A_CTRL = 'h08;
  localparam int A_STAT = 'h44;
  localparam int A_CH0  = 'h0C;
  localparam int A_STEP = 12;

  // per-channel register kinds inside a channel block
  localparam int K_PER = 0;
  localparam int K_CMP = 1;
  localparam int K_OBS = 2;

  // bit offsets inside a channel's control field
  localparam int F_RUN = 0;
  localparam int F_UPD = 1;
  localparam int F_INV = 2;
  localparam int F_RLD = 3;
  localparam int F_DZ  = 4;

  function automatic int ctl_base(input int n);
    return (n == 0) ? 0 : 4 * (n + 1);
  endfunction

  function automatic int ch_addr(input int n, input int kind);
    return A_CH0 + A_STEP * n + 4 * kind;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  input  logic [NCH-1:0][CNT_W-1:0]  ch_count,
  input  logic [NCH-1:0]             ch_expire,
  output logic [NCH-1:0][CNT_W-1:0]  per_buf,
  output logic [NCH-1:0][CNT_W-1:0]  cmp_buf,
  output logic [NCH-1:0]             ctl_run,
  output logic [NCH-1:0]             ctl_upd,
  output logic [NCH-1:0]             ctl_inv,
  output logic [NCH-1:0]             ctl_rld,
  output logic [NCH-1:0]             stat_q
);

  logic [DW-1:0] cfg0_q;
  logic [DW-1:0] cfg1_q;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] rd_next;

  logic hit_cfg0, hit_cfg1, hit_ctrl, hit_stat;
  logic [NCH-1:0] hit_per, hit_cmp, hit_obs;

  assign hit_cfg0 = (bus_addr == ADDR_W'(A_CFG0));
  assign hit_cfg1 = (bus_addr == ADDR_W'(A_CFG1));
  assign hit_ctrl = (bus_addr == ADDR_W'(A_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(A_STAT));

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign hit_per[n] = (bus_addr == ADDR_W'(ch_addr(n, K_PER)));
    assign hit_cmp[n] = (bus_addr == ADDR_W'(ch_addr(n, K_CMP)));
    assign hit_obs[n] = (bus_addr == ADDR_W'(ch_addr(n, K_OBS)));

    // control field unpacking, uneven placement per R3
    assign ctl_run[n] = ctrl_q[ctl_base(n) + F_RUN];
    assign ctl_upd[n] = ctrl_q[ctl_base(n) + F_UPD];
    assign ctl_inv[n] = ctrl_q[ctl_base(n) + F_INV];
    assign ctl_rld[n] = ctrl_q[ctl_base(n) + F_RLD];
  end

  // register storage
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg0_q  <= '0;
      cfg1_q  <= '0;
      ctrl_q  <= '0;
      per_buf <= '0;
      cmp_buf <= '0;
    end else if (bus_wr) begin
      if (hit_cfg0) cfg0_q <= bus_wdata;
      if (hit_cfg1) cfg1_q <= bus_wdata;
      if (hit_ctrl) ctrl_q <= bus_wdata;
      for (int n = 0; n < NCH; n++) begin
        if (hit_per[n]) per_buf[n] <= bus_wdata[CNT_W-1:0];
        if (hit_cmp[n]) cmp_buf[n] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  // interrupt status: set on expiry, write-one-to-clear, set wins
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (ch_expire[n])
          stat_q[n] <= 1'b1;
        else if (bus_wr && hit_stat && bus_wdata[n])
          stat_q[n] <= 1'b0;
      end
    end
  end

  // read multiplexer; status decode is last so it wins at its address
  always_comb begin
    rd_next = '0;
    if (hit_cfg0) rd_next = cfg0_q;
    if (hit_cfg1) rd_next = cfg1_q;
    if (hit_ctrl) rd_next = ctrl_q;
    for (int n = 0; n < NCH; n++) begin
      if (hit_per[n]) rd_next = DW'(per_buf[n]);
      if (hit_cmp[n]) rd_next = DW'(cmp_buf[n]);
      if (hit_obs[n]) rd_next = DW'(ch_count[n]);
    end
    if (hit_stat) rd_next = DW'(stat_q);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             upd,
  input  logic             inv,
  input  logic             rld,
  input  logic [CNT_W-1:0] per_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_act,
  output logic             halted,
  output logic             expire,
  output logic             pwm
);

  logic active;
  logic at_zero;

  assign active  = run && !upd && !halted;
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      cmp_act <= '0;
      halted  <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (upd) begin
        count   <= per_buf;
        cmp_act <= cmp_buf;
        halted  <= 1'b0;
      end else if (active && tick) begin
        if (at_zero) begin
          expire <= 1'b1;
          if (rld) begin
            count   <= per_buf;
            cmp_act <= cmp_buf;
          end else begin
            halted <= 1'b1;
          end
        end else begin
          count <= count - CNT_W'(1);
        end
      end
    end
  end

  // registered output
  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= (active && (count <= cmp_act)) ^ inv;
  end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  logic [NCH-1:0][CNT_W-1:0] per_buf;
  logic [NCH-1:0][CNT_W-1:0] cmp_buf;
  logic [NCH-1:0][CNT_W-1:0] ch_count;
  logic [NCH-1:0][CNT_W-1:0] ch_cmp;
  logic [NCH-1:0] ctl_run, ctl_upd, ctl_inv, ctl_rld;
  logic [NCH-1:0] ch_halt, ch_expire, stat_q;

  pwm_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_count  (ch_count),
    .ch_expire (ch_expire),
    .per_buf   (per_buf),
    .cmp_buf   (cmp_buf),
    .ctl_run   (ctl_run),
    .ctl_upd   (ctl_upd),
    .ctl_inv   (ctl_inv),
    .ctl_rld   (ctl_rld),
    .stat_q    (stat_q)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .run     (ctl_run[n]),
      .upd     (ctl_upd[n]),
      .inv     (ctl_inv[n]),
      .rld     (ctl_rld[n]),
      .per_buf (per_buf[n]),
      .cmp_buf (cmp_buf[n]),
      .count   (ch_count[n]),
      .cmp_act (ch_cmp[n]),
      .halted  (ch_halt[n]),
      .expire  (ch_expire[n]),
      .pwm     (pwm_out[n])
    );
  end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int NCH   = 5,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      tick,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            ctl_run,
  input logic [NCH-1:0]            ctl_upd,
  input logic [NCH-1:0]            ctl_inv,
  input logic [NCH-1:0][CNT_W-1:0] per_buf,
  input logic [NCH-1:0][CNT_W-1:0] ch_count,
  input logic [NCH-1:0][CNT_W-1:0] ch_cmp,
  input logic [NCH-1:0]            ch_halt,
  input logic [NCH-1:0]            ch_expire,
  input logic [NCH-1:0]            stat_q
);

  for (genvar n = 0; n < NCH; n++) begin : g_p
    // R4: update loads the period buffer and clears the halt
    assert_update_load_R4: assert property (@(posedge clk) disable iff (rst)
      ctl_upd[n] |=> (ch_count[n] == $past(per_buf[n])) && !ch_halt[n]);

    // R5: no tick and no update leaves the counter alone
    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
      (!ctl_upd[n] && !tick) |=> $stable(ch_count[n]));

    // R5: running with a tick and a nonzero count steps down by one
    assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
      (ctl_run[n] && !ctl_upd[n] && !ch_halt[n] && tick && ch_count[n] != '0)
      |=> ch_count[n] == $past(ch_count[n]) - CNT_W'(1));

    // R7: output level follows the compare relation one clock later
    assert_out_level_R7: assert property (@(posedge clk) disable iff (rst)
      (ctl_run[n] && !ctl_upd[n] && !ch_halt[n])
      |=> pwm_out[n] == ($past(ch_count[n] <= ch_cmp[n]) ^ $past(ctl_inv[n])));

    // R9: a halted channel shows the idle level and stays at zero
    assert_idle_halt_R9: assert property (@(posedge clk) disable iff (rst)
      (ch_halt[n] && !ctl_upd[n])
      |=> ch_halt[n] && ch_count[n] == '0 && pwm_out[n] == $past(ctl_inv[n]));

    // R10: expiry sets the status bit
    assert_status_set_R10: assert property (@(posedge clk) disable iff (rst)
      ch_expire[n] |=> stat_q[n]);
  end

endmodule

bind pwm_timer pwm_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .pwm_out   (pwm_out),
  .ctl_run   (ctl_run),
  .ctl_upd   (ctl_upd),
  .ctl_inv   (ctl_inv),
  .per_buf   (per_buf),
  .ch_count  (ch_count),
  .ch_cmp    (ch_cmp),
  .ch_halt   (ch_halt),
  .ch_expire (ch_expire),
  .stat_q    (stat_q)
);

// File: tb/tb_pwm_timer.sv
`timescale 1ns/1ps
module tb_pwm_timer;

  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_mode = 0;   // 0 always, 1 every other clock, 2 never
  bit done = 0;
  logic [31:0] shadow = '0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    case (tick_mode)
      0:       tick = 1'b1;
      1:       tick = ~tick;
      default: tick = 1'b0;
    endcase
  end

  pwm_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic int fbase(int n);
    return (n == 0) ? 0 : 4 * (n + 1);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_bit(int n, int f, bit v);
    shadow[fbase(n) + f] = v;
  endtask

  // load buffers, pulse update with reload on, then run
  task automatic program_ch(int n, int per, int cmp, bit inv);
    wr('h0C + 12 * n, 32'(per));
    wr('h10 + 12 * n, 32'(cmp));
    set_bit(n, 0, 0); set_bit(n, 1, 1); set_bit(n, 2, inv); set_bit(n, 3, 1);
    wr('h08, shadow);
    set_bit(n, 1, 0); set_bit(n, 0, 1);
    wr('h08, shadow);
  endtask

  // rise-to-rise interval and high cycles on one output
  task automatic measure(int n, output int per, output int hi);
    logic prev;
    bit   high_phase;
    int   guard;
    per = 0; hi = 0; guard = 0;
    @(negedge clk);
    prev = pwm_out[n];
    forever begin
      @(negedge clk);
      guard++;
      if ((!prev && pwm_out[n]) || guard > 5000) break;
      prev = pwm_out[n];
    end
    high_phase = 1;
    forever begin
      per++;
      if (high_phase && pwm_out[n]) hi++;
      else high_phase = 0;
      @(negedge clk);
      if ((!high_phase && pwm_out[n]) || per > 5000) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "pwm_out after reset", pwm_out, 0);
    rd('h00, d); chk("R1", "config0 after reset", d, 0);
    rd('h08, d); chk("R1", "control after reset", d, 0);
    rd('h44, d); chk("R1", "status after reset", d, 0);
    rd('h14, d); chk("R1", "live count 0 after reset", d, 0);
    rd('h0C, d); chk("R1", "period buffer 0 after reset", d, 0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    wr('h00, 32'hA5C3_0F81);
    wr('h04, 32'h1234_5678);
    rd('h00, d); chk("R2", "config0 readback", d, 32'hA5C3_0F81);
    rd('h04, d); chk("R2", "config1 readback", d, 32'h1234_5678);
    rd('h28, d); chk("R2", "compare buffer 2 untouched", d, 0);
  endtask

  task automatic t_manual_update();
    logic [31:0] d;
    wr('h0C, 200);
    wr('h10, 10);
    rd('h14, d); chk("R4", "buffer write alone leaves counter", d, 0);
    set_bit(0, 1, 1); wr('h08, shadow);
    repeat (3) @(negedge clk);
    rd('h14, d); chk("R4", "counter loaded while update held", d, 200);
    set_bit(0, 1, 0); wr('h08, shadow);
    repeat (5) @(negedge clk);
    rd('h14, d); chk("R5", "stopped channel holds count", d, 200);
    tick_mode = 2;
    set_bit(0, 0, 1); set_bit(0, 3, 1); wr('h08, shadow);
    repeat (10) @(negedge clk);
    rd('h14, d); chk("R5", "no tick keeps count", d, 200);
    tick_mode = 0;
  endtask

  task automatic t_live_count();
    logic [31:0] a, b;
    @(negedge clk);
    bus_addr = 8'h14;
    @(negedge clk); a = bus_rdata;
    repeat (7) @(negedge clk);
    b = bus_rdata;
    chk("R12", "live count drop over 7 ticks", a - b, 7);
  endtask

  task automatic t_waveforms();
    int per, hi;
    program_ch(0, 9, 3, 0);
    program_ch(1, 19, 14, 0);
    program_ch(2, 4, 0, 0);
    program_ch(3, 30, 7, 0);
    program_ch(4, 12, 5, 1);
    measure(0, per, hi); chk("R6", "ch0 period", per, 10); chk("R7", "ch0 high", hi, 4);
    measure(1, per, hi); chk("R6", "ch1 period", per, 20); chk("R7", "ch1 high", hi, 15);
    measure(2, per, hi); chk("R6", "ch2 period", per, 5);  chk("R7", "ch2 high", hi, 1);
    measure(3, per, hi); chk("R6", "ch3 period", per, 31); chk("R7", "ch3 high", hi, 8);
    measure(4, per, hi); chk("R3", "ch4 field at bit 20 period", per, 13);
    chk("R8", "ch4 inverted high", hi, 7);
  endtask

  task automatic t_invert();
    int per, hi;
    program_ch(2, 4, 0, 1);
    measure(2, per, hi); chk("R8", "ch2 inverted period", per, 5);
    chk("R8", "ch2 inverted high", hi, 4);
  endtask

  task automatic t_tick_gate();
    int per, hi;
    tick_mode = 1;
    repeat (30) @(negedge clk);
    measure(0, per, hi);
    chk("R5", "half-rate tick period", per, 20);
    chk("R5", "half-rate tick high", hi, 8);
    tick_mode = 0;
  endtask

  task automatic t_deferred();
    logic [31:0] d;
    int per, hi;
    wr('h30, 100);
    rd('h38, d); chk("R11", "running count not reloaded on write", d <= 30, 1);
    repeat (40) @(negedge clk);
    measure(3, per, hi);
    chk("R11", "new period after reload", per, 101);
    chk("R11", "high time after reload", hi, 8);
  endtask

  task automatic t_stop_and_status();
    logic [31:0] d;
    int per, hi;
    set_bit(1, 3, 0); wr('h08, shadow);
    repeat (60) @(negedge clk);
    chk("R9", "halted ch1 output idle low", pwm_out[1], 0);
    rd('h20, d); chk("R9", "halted ch1 count", d, 0);
    repeat (30) @(negedge clk);
    chk("R9", "ch1 still idle", pwm_out[1], 0);
    set_bit(1, 2, 1); wr('h08, shadow);
    repeat (3) @(negedge clk);
    chk("R8", "halted ch1 inverted idle high", pwm_out[1], 1);
    rd('h44, d); chk("R10", "ch1 status set", d[1], 1);
    wr('h44, 0);
    rd('h44, d); chk("R10", "zero write keeps ch1 status", d[1], 1);
    wr('h44, 32'h2);
    rd('h44, d); chk("R10", "one write clears ch1 status", d[1], 0);
    repeat (20) @(negedge clk);
    rd('h44, d); chk("R10", "halted ch1 does not set again", d[1], 0);
    program_ch(1, 19, 14, 1);
    measure(1, per, hi);
    chk("R9", "ch1 runs again after update", per, 20);
    chk("R8", "ch1 inverted high after restart", hi, 5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_manual_update();
    t_live_count();
    t_waveforms();
    t_invert();
    t_tick_gate();
    t_deferred();
    t_stop_and_status();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule